// File: doc/BRIEF.md
# Platform Activity Window Traffic Gate

This block decides, cycle by cycle, which device-initiated transaction may go out, based on the platform's current power window. The window is one of three states: idle (platform in a low-power state), flush (the memory path is up for reads and writes), or active (the processor and platform are fully awake). A configuration bit picks where the window comes from. One choice is a code from an external wake-pin decoder. The other, for systems without the pin, is the last window message received.

Three pending flags come from the device's request queues: critical DMA, deferrable DMA and deferrable interrupts. The gate raises at most one grant per cycle, and each grant pops one transaction from its queue. Critical work goes out in any window. Deferrable DMA waits for flush or active. Deferrable interrupts wait for active. Held work then drains on consecutive cycles as one burst once its window opens. The occupancy of the deferral buffer is also an input: when it reaches a high watermark, deferrable DMA is promoted so the buffer cannot overrun. The buffer is sized outside this block to cover roughly 300 µs of holding.

Top module: `plat_window_gate`

## Requirements
- R1: After reset the window output is idle (code 0), and neither a deferrable DMA grant nor an interrupt grant is issued until a window opens.
- R2: In message mode (`cfg_use_msg`=1), the code carried by a message with `msg_valid` high sets the window from the next cycle on: 0 gives idle (0), 1 gives flush (1), 2 gives active (2), and 3 is taken as active (2). The window keeps its value until the next message arrives.
- R3: The source select is exclusive. In pin mode (`cfg_use_msg`=0) the window follows `pin_code` one cycle later, using the same code meanings, and messages have no effect on it. In message mode, `pin_code` has no effect on it.
- R4: A pending critical request is granted in every window state and takes priority over all deferrable work.
- R5: Deferrable DMA is not granted in the idle window (unless promoted by R8) and is granted in the flush and active windows.
- R6: Deferrable interrupts are granted only in the active window, and only when no critical or DMA request is granted in that cycle.
- R7: While a window that allows a queue stays open, held work of that queue is granted on consecutive cycles until the queue is empty. Grant priority is critical, then DMA, then interrupt.
- R8: When `fill_level` is at or above the watermark `HIWM`, deferrable DMA is granted in any window, idle included.
- R9: At most one grant is raised per cycle. When the window falls to idle during a DMA burst, the last DMA grant is in the final cycle of the open window, and no DMA grant follows once the window is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_use_msg | input | 1 | 1: window comes from messages; 0: window comes from the pin decoder |
| pin_code | input | 2 | Window code from the wake-pin decoder |
| msg_valid | input | 1 | A window message is present this cycle |
| msg_code | input | 2 | Window code carried by the message |
| crit_pend | input | 1 | Critical DMA queue is non-empty |
| dma_pend | input | 1 | Deferrable DMA queue is non-empty |
| irq_pend | input | 1 | Deferrable interrupt queue is non-empty |
| fill_level | input | FILL_W | Deferral buffer occupancy |
| gnt_crit | output | 1 | Pop and issue one critical transaction |
| gnt_dma | output | 1 | Pop and issue one deferrable DMA transaction |
| gnt_irq | output | 1 | Pop and issue one deferrable interrupt |
| win_state | output | 2 | Current window: 0 idle, 1 flush, 2 active |

## Verification
The bench builds the gate with `FILL_W`=6 and `HIWM`=48. With these values, a level of 50 lies above the watermark and 10 lies below it, so promotion can be switched on and off within a short run. The scoreboard tracks how deep each queue is, along with the window value it expects from both sources. This lets it predict every grant cycle: bursts that drain, interrupts that stay held during flush, code 3, the source switch, and a burst cut off when the window closes.

// File: rtl/plat_window_gate.sv
module plat_window_gate #(
  parameter int FILL_W = 8,
  parameter int HIWM   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_use_msg,
  input  logic [1:0]        pin_code,
  input  logic              msg_valid,
  input  logic [1:0]        msg_code,
  input  logic              crit_pend,
  input  logic              dma_pend,
  input  logic              irq_pend,
  input  logic [FILL_W-1:0] fill_level,
  output logic              gnt_crit,
  output logic              gnt_dma,
  output logic              gnt_irq,
  output logic [1:0]        win_state
);
  localparam logic [1:0]        W_IDLE = 2'd0;
  localparam logic [1:0]        W_ACT  = 2'd2;
  localparam logic [FILL_W-1:0] HIWM_V = FILL_W'(HIWM);

  function automatic logic [1:0] decode(input logic [1:0] c);
    return (c == 2'd3) ? W_ACT : c;
  endfunction

  logic [1:0] pin_q, msg_q;
  logic       promote, dma_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= W_IDLE;
      msg_q <= W_IDLE;
    end else begin
      pin_q <= decode(pin_code);
      if (msg_valid) msg_q <= decode(msg_code);
    end
  end

  assign win_state = cfg_use_msg ? msg_q : pin_q;
  assign promote   = fill_level >= HIWM_V;
  assign dma_ok    = promote || (win_state != W_IDLE);

  assign gnt_crit = crit_pend;
  assign gnt_dma  = !crit_pend && dma_pend && dma_ok;
  assign gnt_irq  = !crit_pend && !gnt_dma && irq_pend && (win_state == W_ACT);
endmodule

// File: rtl/plat_window_gate_chk.sv
module plat_window_gate_chk #(
  parameter int FILL_W = 8,
  parameter int HIWM   = 200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_use_msg,
  input logic              msg_valid,
  input logic [1:0]        msg_code,
  input logic              crit_pend,
  input logic              dma_pend,
  input logic [FILL_W-1:0] fill_level,
  input logic              gnt_crit,
  input logic              gnt_dma,
  input logic              gnt_irq,
  input logic [1:0]        win_state
);
  localparam logic [FILL_W-1:0] HI = FILL_W'(HIWM);

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_crit, gnt_dma, gnt_irq}));

  assert_crit_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    crit_pend |-> gnt_crit);

  assert_irq_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_irq |-> win_state == 2'd2);

  assert_dma_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_dma && fill_level < HI) |-> win_state != 2'd0);

  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pend && !crit_pend && win_state != 2'd0) |-> gnt_dma);

  assert_promote_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level >= HI && dma_pend && !crit_pend) |-> gnt_dma);

  assert_code3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_use_msg && msg_valid && msg_code == 2'd3) |=> (!cfg_use_msg || win_state == 2'd2));

  assert_msg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_use_msg && !msg_valid) |=> (!cfg_use_msg || $stable(win_state)));
endmodule

bind plat_window_gate plat_window_gate_chk #(.FILL_W(FILL_W), .HIWM(HIWM)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_use_msg(cfg_use_msg), .msg_valid(msg_valid),
  .msg_code(msg_code), .crit_pend(crit_pend), .dma_pend(dma_pend),
  .fill_level(fill_level), .gnt_crit(gnt_crit), .gnt_dma(gnt_dma),
  .gnt_irq(gnt_irq), .win_state(win_state)
);

// File: tb/plat_window_gate_tb.sv
module plat_window_gate_tb;
  localparam int FW = 6;
  localparam int HI = 48;

  logic clk = 0, rst_n = 0;
  logic cfg_use_msg = 0, msg_valid = 0, crit_pend = 0, dma_pend = 0, irq_pend = 0;
  logic [1:0] pin_code = 0, msg_code = 0, win_state;
  logic [FW-1:0] fill_level = 0;
  logic gnt_crit, gnt_dma, gnt_irq;

  always #2 clk = ~clk;

  plat_window_gate #(.FILL_W(FW), .HIWM(HI)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_use_msg(cfg_use_msg), .pin_code(pin_code),
    .msg_valid(msg_valid), .msg_code(msg_code), .crit_pend(crit_pend),
    .dma_pend(dma_pend), .irq_pend(irq_pend), .fill_level(fill_level),
    .gnt_crit(gnt_crit), .gnt_dma(gnt_dma), .gnt_irq(gnt_irq), .win_state(win_state)
  );

  int checks = 0, fails = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];

  logic s_cfg = 0, s_mv = 0;
  logic [1:0] s_pin = 0, s_mc = 0;
  logic [FW-1:0] s_fill = 0;
  int n_crit = 0, n_dma = 0, n_irq = 0;
  logic [1:0] m_pin = 0, m_msg = 0;

  function automatic logic [1:0] wdec(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction

  task automatic report(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {crit,dma,irq,win} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic [1:0] cur;
    logic ec, ed, ei;
    @(negedge clk);
    cfg_use_msg = s_cfg; pin_code = s_pin; msg_valid = s_mv; msg_code = s_mc;
    fill_level = s_fill;
    crit_pend = n_crit > 0; dma_pend = n_dma > 0; irq_pend = n_irq > 0;
    cur = s_cfg ? m_msg : m_pin;
    ec = crit_pend;
    ed = !ec && dma_pend && (cur != 2'd0 || int'(s_fill) >= HI);
    ei = !ec && !ed && irq_pend && cur == 2'd2;
    exp_q.push_back({ec, ed, ei, cur});
    tag_q.push_back(tag);
    if (ec) n_crit--;
    if (ed) n_dma--;
    if (ei) n_irq--;
    m_pin = wdec(s_pin);
    if (s_mv) m_msg = wdec(s_mc);
    s_mv = 0;
  endtask

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      report(t, {gnt_crit, gnt_dma, gnt_irq, win_state}, e);
    end
  end

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    report("R1 reset", {gnt_crit, gnt_dma, gnt_irq, win_state}, 5'b0);
    rst_n = 1;

    n_dma = 3; n_irq = 2;
    repeat (3) step("R1 R5 idle holds");
    n_crit = 2;
    repeat (3) step("R4 critical in idle");

    s_pin = 2'd1;
    repeat (6) step("R7 R6 flush drains dma, irq held");
    s_pin = 2'd2;
    repeat (4) step("R6 active irq");

    n_crit = 1; n_dma = 1; n_irq = 1;
    repeat (4) step("R4 R7 priority");

    s_cfg = 1; n_dma = 2;
    repeat (2) step("R3 pin ignored in msg mode");
    s_mv = 1; s_mc = 2'd1;
    repeat (4) step("R2 code1 flush");
    n_irq = 1;
    repeat (2) step("R2 flush holds irq");
    s_mv = 1; s_mc = 2'd3;
    repeat (3) step("R2 code3 active");
    s_mv = 1; s_mc = 2'd0; n_irq = 1; n_dma = 1;
    repeat (3) step("R2 code0 idle");
    s_mv = 1; s_mc = 2'd2;
    repeat (4) step("R2 code2 active");

    s_cfg = 0; s_pin = 2'd1; s_mv = 1; s_mc = 2'd0;
    repeat (3) step("R3 msg ignored in pin mode");
    s_mv = 1; s_mc = 2'd2; n_irq = 1;
    repeat (2) step("R3 pin flush despite msg");
    s_pin = 2'd0;
    repeat (3) step("R3 pin idle");
    n_irq = 0;

    s_pin = 2'd0; n_dma = 3; s_fill = 6'd50;
    repeat (2) step("R8 promoted in idle");
    s_fill = 6'd10;
    repeat (2) step("R8 below watermark held");
    s_fill = 6'd48;
    repeat (2) step("R8 at watermark");
    s_fill = 0;

    s_pin = 2'd1;
    step("R9 open");
    n_dma = 6;
    repeat (2) step("R9 burst");
    s_pin = 2'd0;
    repeat (3) step("R9 close stops burst");
    s_pin = 2'd3;
    repeat (4) step("R3 pin code3 active resumes");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule